// File: doc/BRIEF.md
# Control-Word Register Datapath

This block is a single-cycle register-transfer datapath. It holds eight general registers and a combinational function unit. A 16-bit control word, applied for one clock period, selects everything the datapath does in that cycle:
- which two registers are read onto the A and B buses;
- whether an external constant replaces the B register on bus B;
- which function the unit computes;
- whether the function result or external input data is routed onto bus D;
- whether bus D is written into a destination register at the next rising edge.

Bus A is always visible as an address output and bus B as a data output. A surrounding memory or port can therefore be addressed and written in a cycle that changes no register, by clearing the write bit. The function unit also produces four combinational status flags: overflow, carry, negative and zero.

The register file and function unit are parameterised in data width. The register address width stays at three bits, because the control word layout fixes it. The reset input is asynchronous and active low. Inside the block its release is synchronised to the clock.

Top module: `cwdp_top`

## Requirements
- R1: While `rst_n` is low, and after it is released, every register reads as zero until it is written. Released reset takes effect from the third rising edge after `rst_n` rises.
- R2: The control word fields are laid out as follows: `ctrl_word[15:13]` destination address, `[12:10]` A address, `[9:7]` B address, `[6]` B-source select, `[5:2]` function code, `[1]` D-source select and `[0]` write enable. Bus A is the register at the A address and drives `addr_out` at all times.
- R3: When bit 6 is 0, bus B is the register at the B address. When it is 1, bus B is `const_in`. Bus B drives `data_out` at all times.
- R4: When bit 1 is 0, bus D is the function result. When it is 1, bus D is `data_in`.
- R5: When bit 0 is 1, the register at the destination address loads bus D at the rising edge. When bit 0 is 0, no register changes, whatever the other fields and inputs hold.
- R6: The arithmetic function codes compute A plus Y plus a carry-in. For codes 0000 to 0111, in that order, the results are: A, A+1, A+B, A+B+1, A+~B, A+~B+1 (A−B), A−1, and A. Carry is the adder carry-out. Overflow is set when A and Y have the same sign and the result's sign differs.
- R7: The logic codes are 1000 AND, 1001 OR, 1010 XOR and 1011 NOT A.
- R8: The shift codes are 1100 pass B, 1101 B shifted right one place with zero fill, 1110 B shifted left one place with zero fill, and 1111 pass B.
- R9: Negative is the result MSB and zero flags an all-zero result. Both are combinational in the same cycle. For codes 1000 to 1111, overflow and carry are 0.
- R10: When a register is read and written in the same cycle, the read returns the old value. The new value is visible from the next cycle on.
- R11: The transfer R0 ← R1 + R2 uses control word 000_001_010_0_0010_0_1. It completes in one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 16 | Control word for the current cycle |
| const_in | input | DATA_W | Constant that may replace bus B |
| data_in | input | DATA_W | External data that may drive bus D |
| addr_out | output | DATA_W | Bus A |
| data_out | output | DATA_W | Bus B |
| stat_v | output | 1 | Overflow flag |
| stat_c | output | 1 | Carry flag |
| stat_n | output | 1 | Negative flag |
| stat_z | output | 1 | Zero flag |

## Verification
Two functions can fall in the same cycle: a read of a register and a write of that same register. The bench provokes this with a control word whose A, B and destination addresses are equal. It checks that `addr_out` still shows the old contents before the edge, and the constant that was written after the edge.

A second overlap is an external memory write (address and data on the outputs) with the write bit low. In that cycle the bench drives a nonzero `data_in` and a nonzero destination address. It then reads back all eight registers through bus A to show that none moved.

// File: rtl/cwdp_pkg.sv
package cwdp_pkg;

  localparam int CW_ADDR_W = 3;
  localparam int CW_FS_W   = 4;
  localparam int CW_W      = 3 * CW_ADDR_W + CW_FS_W + 3;

  typedef struct packed {
    logic [CW_ADDR_W-1:0] dst;
    logic [CW_ADDR_W-1:0] src_a;
    logic [CW_ADDR_W-1:0] src_b;
    logic                 b_const;
    logic [CW_FS_W-1:0]   fsel;
    logic                 d_ext;
    logic                 wr;
  } ctrl_word_t;

  // Function codes; the bit pattern is decoded inside the function unit.
  typedef enum logic [CW_FS_W-1:0] {
    FS_PASS_A = 4'b0000,
    FS_INC    = 4'b0001,
    FS_ADD    = 4'b0010,
    FS_ADD_C  = 4'b0011,
    FS_ADD_NB = 4'b0100,
    FS_SUB    = 4'b0101,
    FS_DEC    = 4'b0110,
    FS_XFER   = 4'b0111,
    FS_AND    = 4'b1000,
    FS_OR     = 4'b1001,
    FS_XOR    = 4'b1010,
    FS_NOT    = 4'b1011,
    FS_PASS_B = 4'b1100,
    FS_SHR    = 4'b1101,
    FS_SHL    = 4'b1110,
    FS_PASS_B2= 4'b1111
  } fs_code_e;

  typedef enum logic [1:0] {
    UNIT_ARITH = 2'b00,
    UNIT_LOGIC = 2'b10,
    UNIT_SHIFT = 2'b11
  } unit_sel_e;

endpackage

// File: rtl/cwdp_rst_sync.sv
module cwdp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/cwdp_regfile.sv
module cwdp_regfile #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_a_addr,
  input  logic [ADDR_W-1:0] rd_b_addr,
  output logic [DATA_W-1:0] rd_a_data,
  output logic [DATA_W-1:0] rd_b_data
);

  localparam int REG_CNT = 1 << ADDR_W;

  logic [REG_CNT-1:0][DATA_W-1:0] regs_q;
  logic [REG_CNT-1:0]             load_en;

  // Destination decode: one clock enable per register.
  generate
    for (genvar g = 0; g < REG_CNT; g++) begin : g_dec
      assign load_en[g] = wr_en && (wr_addr == ADDR_W'(g));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else begin
      for (int i = 0; i < REG_CNT; i++) begin
        if (load_en[i]) begin
          regs_q[i] <= wr_data;
        end
      end
    end
  end

  // Reads see the stored value only: no bypass from the write port.
  assign rd_a_data = regs_q[rd_a_addr];
  assign rd_b_data = regs_q[rd_b_addr];

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (regs_q == '0));

  assert_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (regs_q[$past(wr_addr)] == $past(wr_data)));

  assert_no_write_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (regs_q == $past(regs_q)));

endmodule

// File: rtl/cwdp_func_unit.sv
module cwdp_func_unit
  import cwdp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0]  op_a,
  input  logic [DATA_W-1:0]  op_b,
  input  logic [CW_FS_W-1:0] fsel,
  output logic [DATA_W-1:0]  result,
  output logic               flag_v,
  output logic               flag_c,
  output logic               flag_n,
  output logic               flag_z
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] y_in;
  logic [DATA_W:0]   sum;
  logic [DATA_W-1:0] logic_res;
  logic [DATA_W-1:0] shift_res;
  logic              arith_v;
  unit_sel_e         unit;

  // Adder B-input select from fsel[2:1], carry-in from fsel[0].
  always_comb begin
    case (fsel[2:1])
      2'b00:   y_in = '0;
      2'b01:   y_in = op_b;
      2'b10:   y_in = ~op_b;
      default: y_in = '1;
    endcase
    sum     = {1'b0, op_a} + {1'b0, y_in} + {{DATA_W{1'b0}}, fsel[0]};
    arith_v = (op_a[MSB] == y_in[MSB]) && (sum[MSB] != op_a[MSB]);
  end

  always_comb begin
    case (fsel[1:0])
      2'b00:   logic_res = op_a & op_b;
      2'b01:   logic_res = op_a | op_b;
      2'b10:   logic_res = op_a ^ op_b;
      default: logic_res = ~op_a;
    endcase
  end

  always_comb begin
    case (fsel[1:0])
      2'b01:   shift_res = {1'b0, op_b[MSB:1]};
      2'b10:   shift_res = {op_b[MSB-1:0], 1'b0};
      default: shift_res = op_b;
    endcase
  end

  always_comb begin
    unit = fsel[3] ? unit_sel_e'({1'b1, fsel[2]}) : UNIT_ARITH;
    case (unit)
      UNIT_LOGIC: begin
        result = logic_res;
        flag_v = 1'b0;
        flag_c = 1'b0;
      end
      UNIT_SHIFT: begin
        result = shift_res;
        flag_v = 1'b0;
        flag_c = 1'b0;
      end
      default: begin
        result = sum[MSB:0];
        flag_v = arith_v;
        flag_c = sum[DATA_W];
      end
    endcase
    flag_n = result[MSB];
    flag_z = (result == '0);
  end

endmodule

// File: rtl/cwdp_top.sv
module cwdp_top
  import cwdp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW_W-1:0]   ctrl_word,
  input  logic [DATA_W-1:0] const_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] addr_out,
  output logic [DATA_W-1:0] data_out,
  output logic              stat_v,
  output logic              stat_c,
  output logic              stat_n,
  output logic              stat_z
);

  ctrl_word_t        cw;
  logic              rst_sync_n;
  logic [DATA_W-1:0] rd_a;
  logic [DATA_W-1:0] rd_b;
  logic [DATA_W-1:0] bus_a;
  logic [DATA_W-1:0] bus_b;
  logic [DATA_W-1:0] bus_d;
  logic [DATA_W-1:0] fu_out;

  assign cw = ctrl_word_t'(ctrl_word);

  cwdp_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cwdp_regfile #(.DATA_W(DATA_W), .ADDR_W(CW_ADDR_W)) regfile_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (cw.wr),
    .wr_addr   (cw.dst),
    .wr_data   (bus_d),
    .rd_a_addr (cw.src_a),
    .rd_b_addr (cw.src_b),
    .rd_a_data (rd_a),
    .rd_b_data (rd_b)
  );

  always_comb begin
    bus_a = rd_a;
    bus_b = cw.b_const ? const_in : rd_b;
  end

  cwdp_func_unit #(.DATA_W(DATA_W)) func_i (
    .op_a   (bus_a),
    .op_b   (bus_b),
    .fsel   (cw.fsel),
    .result (fu_out),
    .flag_v (stat_v),
    .flag_c (stat_c),
    .flag_n (stat_n),
    .flag_z (stat_z)
  );

  always_comb begin
    bus_d = cw.d_ext ? data_in : fu_out;
  end

  assign addr_out = bus_a;
  assign data_out = bus_b;

  // A register written last cycle and read now shows what bus D carried then.
  assert_read_after_write_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $past(cw.wr) && (cw.src_a == $past(cw.dst)))
      |-> (addr_out == $past(bus_d)));

  assert_logic_flags_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cw.fsel[3] |-> (!stat_v && !stat_c));

  assert_zero_not_neg_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stat_z |-> !stat_n);

endmodule

// File: tb/cwdp_top_tb_top.sv
`timescale 1ns/1ps
module cwdp_top_tb_top;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [15:0]  ctrl_word;
  logic [W-1:0] const_in;
  logic [W-1:0] data_in;
  logic [W-1:0] addr_out;
  logic [W-1:0] data_out;
  logic         stat_v, stat_c, stat_n, stat_z;

  int n_checks = 0;
  int n_fails  = 0;
  logic [W-1:0] mreg [8];

  always #5 clk = ~clk;

  cwdp_top #(.DATA_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .const_in(const_in),
    .data_in(data_in), .addr_out(addr_out), .data_out(data_out),
    .stat_v(stat_v), .stat_c(stat_c), .stat_n(stat_n), .stat_z(stat_z)
  );

  function automatic logic [15:0] mk(int da, int aa, int ba, int mb, int fs, int md, int rw);
    logic [15:0] r;
    r = {da[2:0], aa[2:0], ba[2:0], mb[0], fs[3:0], md[0], rw[0]};
    return r;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic [15:0] cw, logic [W-1:0] k, logic [W-1:0] d);
    ctrl_word = cw;
    const_in  = k;
    data_in   = d;
    #1;
  endtask

  task automatic edge_step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(int idx, output logic [W-1:0] v);
    drive(mk(0, idx, 0, 0, 0, 0, 0), 8'h00, 8'h00);
    v = addr_out;
  endtask

  task automatic wr(int idx, logic [W-1:0] v);
    drive(mk(idx, 0, 0, 0, 0, 1, 1), 8'h00, v);
    edge_step();
    mreg[idx] = v;
  endtask

  task automatic check_all_regs(string req);
    logic [W-1:0] v;
    for (int i = 0; i < 8; i++) begin
      rd(i, v);
      check(req, $sformatf("R%0d contents", i), v, mreg[i]);
    end
  endtask

  // Expected function result and flags, from the code table of R6-R8.
  task automatic ref_fu(int fs, logic [W-1:0] a, logic [W-1:0] b,
                        output logic [W-1:0] f, output logic v, output logic c);
    int full;
    int y;
    v = 1'b0;
    c = 1'b0;
    if (fs < 8) begin
      case (fs)
        0: begin y = 0;    full = a; end
        1: begin y = 0;    full = a + 1; end
        2: begin y = b;    full = a + b; end
        3: begin y = b;    full = a + b + 1; end
        4: begin y = 255 - b; full = a + y; end
        5: begin y = 255 - b; full = a + y + 1; end
        6: begin y = 255;  full = a + 255; end
        default: begin y = 255; full = a + 256; end
      endcase
      f = full[7:0];
      c = full > 255;
      v = (a[7] == y[7]) && (f[7] != a[7]);
    end else begin
      case (fs)
        8:  f = a & b;
        9:  f = a | b;
        10: f = a ^ b;
        11: f = ~a;
        13: f = b >> 1;
        14: f = b << 1;
        default: f = b;
      endcase
    end
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    rst_n = 1'b0;
    drive(16'h0000, 8'h00, 8'h00);
    repeat (3) edge_step();
    for (int i = 0; i < 8; i++) begin
      rd(i, v);
      check("R1", $sformatf("R%0d during reset", i), v, 0);
      mreg[i] = '0;
    end
    rst_n = 1'b1;
    repeat (3) edge_step();
    check_all_regs("R1");
  endtask

  task automatic t_example_add();
    wr(1, 8'h15);
    wr(2, 8'h27);
    drive(16'b000_001_010_0_0010_0_1, 8'h00, 8'h00);
    check("R2", "addr_out shows R1", addr_out, 8'h15);
    edge_step();
    mreg[0] = 8'h3C;
    check_all_regs("R11");
  endtask

  task automatic t_mux_b();
    wr(5, 8'hA5);
    drive(mk(0, 0, 5, 0, 12, 0, 0), 8'h3C, 8'h00);
    check("R3", "data_out from register", data_out, 8'hA5);
    drive(mk(0, 0, 5, 1, 12, 0, 0), 8'h3C, 8'h00);
    check("R3", "data_out from constant", data_out, 8'h3C);
    drive(mk(6, 5, 5, 1, 2, 0, 1), 8'h10, 8'h00);
    edge_step();
    mreg[6] = 8'hB5;
    check_all_regs("R3");
  endtask

  task automatic t_mux_d();
    wr(3, 8'h40);
    drive(mk(7, 3, 3, 0, 0, 1, 1), 8'h00, 8'h9E);
    edge_step();
    mreg[7] = 8'h9E;
    drive(mk(4, 3, 3, 0, 0, 0, 1), 8'h00, 8'h9E);
    edge_step();
    mreg[4] = 8'h40;
    check_all_regs("R4");
  endtask

  task automatic t_no_write();
    for (int i = 0; i < 8; i++) wr(i, 8'(8'h11 * (i + 1)));
    drive(mk(5, 2, 6, 1, 2, 1, 0), 8'h77, 8'hE1);
    check("R2", "memory address on addr_out", addr_out, mreg[2]);
    check("R3", "memory data on data_out", data_out, 8'h77);
    edge_step();
    drive(mk(3, 1, 4, 0, 9, 0, 0), 8'h00, 8'h5A);
    edge_step();
    check_all_regs("R5");
  endtask

  task automatic t_arith();
    logic [W-1:0] av [4] = '{8'h7F, 8'h80, 8'h00, 8'h35};
    logic [W-1:0] bv [4] = '{8'h01, 8'hFF, 8'h00, 8'hC2};
    logic [W-1:0] f, got;
    logic v, c;
    for (int p = 0; p < 4; p++) begin
      wr(1, av[p]);
      wr(2, bv[p]);
      for (int fs = 0; fs < 16; fs++) begin
        ref_fu(fs, av[p], bv[p], f, v, c);
        drive(mk(3, 1, 2, 0, fs, 0, 1), 8'h00, 8'h00);
        check(fs < 8 ? "R6" : "R9", $sformatf("V fs=%0d", fs), stat_v, v);
        check(fs < 8 ? "R6" : "R9", $sformatf("C fs=%0d", fs), stat_c, c);
        check("R9", $sformatf("N fs=%0d", fs), stat_n, f[7]);
        check("R9", $sformatf("Z fs=%0d", fs), stat_z, f == 0);
        edge_step();
        mreg[3] = f;
        rd(3, got);
        check(fs < 8 ? "R6" : (fs < 12 ? "R7" : "R8"),
              $sformatf("result fs=%0d a=%0h b=%0h", fs, av[p], bv[p]), got, f);
      end
    end
  endtask

  task automatic t_shift_const();
    logic [W-1:0] got;
    drive(mk(2, 0, 0, 1, 13, 0, 1), 8'h81, 8'h00);
    edge_step();
    rd(2, got);
    check("R8", "shift right zero fill", got, 8'h40);
    drive(mk(2, 0, 0, 1, 14, 0, 1), 8'h81, 8'h00);
    edge_step();
    rd(2, got);
    check("R8", "shift left zero fill", got, 8'h02);
    mreg[2] = 8'h02;
  endtask

  task automatic t_same_reg();
    wr(4, 8'h11);
    drive(mk(4, 4, 4, 1, 12, 0, 1), 8'h22, 8'h00);
    check("R10", "old value before edge", addr_out, 8'h11);
    check("R10", "data_out shows constant", data_out, 8'h22);
    edge_step();
    #1;
    check("R10", "new value after edge", addr_out, 8'h22);
    mreg[4] = 8'h22;
  endtask

  initial begin
    ctrl_word = '0;
    const_in  = '0;
    data_in   = '0;
    rst_n     = 1'b0;
    @(negedge clk);
    t_reset();
    t_example_add();
    t_mux_b();
    t_mux_d();
    t_no_write();
    t_arith();
    t_shift_const();
    t_same_reg();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #2000000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule